// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block sits beside a processor core. It gathers interrupt requests from seven fixed priority levels and hands the core one request line and a vector address. The sources are a non-maskable reset request, three active-low external request pins, transmit and receive events from two serial ports, and a timer. The two lowest-priority external pins share their levels with the second serial port, and one select bit per shared level decides which source owns it. The pending requests are gated by a per-level mask and by the nesting rules. The highest-priority request that survives is then presented as `irq_out` with its vector.

The core takes a request by pulsing `ack` while `irq_out` is high. That marks the presented level as in service and clears an edge-latched or event-latched request. A pulse on `rti` retires the level currently in service. The in-service levels are tracked as one bit per level. With nesting enabled, only a level of strictly higher priority than the one in service is issued. With nesting disabled, nothing but the reset level is issued until the in-service set is empty again.

Top module: `irq_vec_ctl`

## Requirements
- R1: `sys_rst_req` (level 0) is presented with vector `VEC_BASE` whenever it is high and level 0 is not in service, whatever the mask, the nesting mode and the other in-service levels.
- R2: The vector for level k is `VEC_BASE + k*VEC_STRIDE`. With the defaults (0, 4), the vectors are 0x00 reset, 0x04 pin 2, 0x08 port-0 transmit, 0x0C port-0 receive, 0x10 shared A, 0x14 shared B and 0x18 timer.
- R3: `irq_mask[k-1]` enables level k for k = 1..6, where 1 means enabled. A pending request whose bit is 0 is never presented.
- R4: Among the pending, enabled and allowed levels, the one with the lowest level number is presented. `irq_out` is low when there is none.
- R5: When `ext_edge_mode[j]` is 0, pin j requests while `ext_req_n[j]` is low. Nothing is held once the pin returns high.
- R6: When `ext_edge_mode[j]` is 1, a high-to-low transition on `ext_req_n[j]` latches a request. The latch stays set after the pin rises and is cleared only when its level is acknowledged.
- R7: A one-cycle pulse on a serial-port or timer event input latches a request. The request stays pending until its level is acknowledged.
- R8: Pin 1 feeds level 4 and pin 0 feeds level 5 when `shared_pin_sel[0]` or `shared_pin_sel[1]` respectively is 1. Otherwise those levels are fed by `sp1_tx_evt` and `sp1_rx_evt`. The source that is not selected has no effect on the level.
- R9: `ack` sampled high while `irq_out` is high puts the presented level in service. `ack` while `irq_out` is low changes nothing.
- R10: With `nest_en` low and any level in service, no level other than 0 is presented.
- R11: With `nest_en` high, only levels with a lower number than the highest-priority in-service level are presented.
- R12: `rti` takes the highest-priority in-service level out of service, so the previously interrupted level becomes current again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_rst_req | input | 1 | Non-maskable level-0 request |
| ext_req_n | input | 3 | Active-low external request pins; bit 2 feeds level 1, bit 1 level 4, bit 0 level 5 |
| ext_edge_mode | input | 3 | Per-pin mode: 1 means falling-edge latched, 0 means level |
| shared_pin_sel | input | 2 | Owner of levels 4 and 5: 1 means pin, 0 means serial port 1 |
| sp0_tx_evt | input | 1 | Serial port 0 transmit event pulse (level 2) |
| sp0_rx_evt | input | 1 | Serial port 0 receive event pulse (level 3) |
| sp1_tx_evt | input | 1 | Serial port 1 transmit event pulse (level 4) |
| sp1_rx_evt | input | 1 | Serial port 1 receive event pulse (level 5) |
| tmr_evt | input | 1 | Timer event pulse (level 6) |
| irq_mask | input | 6 | Enable bit per maskable level; bit k-1 is level k |
| nest_en | input | 1 | Allows higher-priority pre-emption of an active routine |
| ack | input | 1 | Core accepts the presented request |
| rti | input | 1 | Core returns from the current routine |
| irq_out | output | 1 | Request to the core |
| vec_addr | output | VEC_W | Vector address of the presented level |

## Verification
The hardest state to reach is a stack of two in-service levels with a third request pending between them. In that state one `rti` must make the pending level appear, and a second must let a lower-priority latched request through. The bench builds it from the ports. It acknowledges a timer event, lets a pin request pre-empt it under nesting, and then posts a serial-port event whose priority lies between the two. A sweep over every subset of the six maskable sources against every mask value covers the selection logic.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int unsigned IVC_LEVELS = 7;
   localparam int unsigned IVC_LVL_W  = $clog2(IVC_LEVELS);
   localparam int unsigned IVC_PINS   = 3;
   localparam int unsigned IVC_MASK_W = IVC_LEVELS - 1;

   typedef enum logic [IVC_LVL_W-1:0] {
      LVL_SYSRST  = 3'd0,
      LVL_PIN_HI  = 3'd1,
      LVL_P0_TX   = 3'd2,
      LVL_P0_RX   = 3'd3,
      LVL_SHR_A   = 3'd4,
      LVL_SHR_B   = 3'd5,
      LVL_TIMER   = 3'd6
   } ivc_level_e;
endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic req
);
   logic pin_s;
   logic prev_q;
   logic latch_q;
   logic fall;

   generate
      if (SYNC_STAGES > 3) begin : g_bad_sync
         $error("irq_pin_capture: SYNC_STAGES must be 0..3");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = pin_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         logic [SYNC_STAGES:0]   sh_nxt;
         assign sh_nxt = {sh_q, pin_n};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_nxt[SYNC_STAGES-1:0];
         end
         assign pin_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign fall = prev_q & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= pin_s;
         latch_q <= edge_mode & (fall | (latch_q & ~clr));
      end
   end

   assign req = edge_mode ? latch_q : ~pin_s;

   // R6: a falling edge in edge mode is captured
   a_r6_fall_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && fall) |=> latch_q);
   // R6: the latch survives the pin rising until a clear
   a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && latch_q && !clr) |=> latch_q);
endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic accept,
   input  logic clr,
   output logic pend
);
   logic take_evt;
   assign take_evt = evt & accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= take_evt | (pend & ~clr);
   end

   // R7: an accepted pulse always leaves the request pending
   a_r7_evt_captured: assert property (@(posedge clk) disable iff (!rst_n)
      take_evt |=> pend);
   // R8: a refused pulse cannot create a request
   a_r8_refused_evt: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !take_evt) |=> !pend);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N   = 7,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   logic [N:0] seen;

   generate
      if (N < 2) begin : g_bad_n
         $error("irq_prio_pick: N must be at least 2");
      end
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign grant[i]  = req[i] & ~seen[i];
         assign seen[i+1] = seen[i] | req[i];
      end
   endgenerate

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end

   // R4: at most one level is granted
   a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R4: a grant exists exactly when something requests
   a_r4_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> ($countones(grant) == 1));
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         nest_en,
   input  logic [N-1:0] push,
   input  logic         pop,
   output logic [N-1:0] act,
   output logic [N-1:0] allow
);
   logic [N:0]   seen;
   logic [N-1:0] cur;
   logic         busy;

   generate
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < N; i++) begin : g_lvl
         assign seen[i+1] = seen[i] | act[i];
         assign cur[i]    = act[i] & ~seen[i];
         if (i == 0) begin : g_top
            assign allow[i] = ~act[0];
         end else begin : g_rest
            assign allow[i] = ~busy | (nest_en & ~seen[i+1]);
         end
      end
   endgenerate

   assign busy = seen[N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act <= '0;
      else        act <= (act & ~(pop ? cur : '0)) | push;
   end

   // R9: a level enters service only through an accepted push
   a_r9_enter_by_push: assert property (@(posedge clk) disable iff (!rst_n)
      ((act & ~$past(act)) != '0) |-> ($past(push) != '0));
   // R12: a return with nothing pushed retires exactly one level
   a_r12_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && busy && push == '0) |=> ($countones(act) == $countones($past(act)) - 1));
   // R12: a return never retires a lower-priority level ahead of a higher one
   a_r12_pop_top: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && busy && push == '0) |=> ((act & ~$past(act & ~cur)) == '0));
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
   import irq_vec_pkg::*;
#(
   parameter int unsigned VEC_W           = 16,
   parameter int unsigned VEC_BASE        = 0,
   parameter int unsigned VEC_STRIDE      = 4,
   parameter int unsigned PIN_SYNC_STAGES = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sys_rst_req,
   input  logic [IVC_PINS-1:0]   ext_req_n,
   input  logic [IVC_PINS-1:0]   ext_edge_mode,
   input  logic [1:0]            shared_pin_sel,
   input  logic                  sp0_tx_evt,
   input  logic                  sp0_rx_evt,
   input  logic                  sp1_tx_evt,
   input  logic                  sp1_rx_evt,
   input  logic                  tmr_evt,
   input  logic [IVC_MASK_W-1:0] irq_mask,
   input  logic                  nest_en,
   input  logic                  ack,
   input  logic                  rti,
   output logic                  irq_out,
   output logic [VEC_W-1:0]      vec_addr
);
   localparam int unsigned N        = IVC_LEVELS;
   localparam int unsigned LW       = IVC_LVL_W;
   localparam longint unsigned TOPV = longint'(VEC_BASE) + longint'(VEC_STRIDE) * (N - 1);

   generate
      if (VEC_STRIDE == 0 || (VEC_STRIDE & (VEC_STRIDE - 1)) != 0) begin : g_bad_stride
         $error("irq_vec_ctl: VEC_STRIDE must be a power of two");
      end
      if (VEC_W > 32 || TOPV >= (64'd1 << VEC_W)) begin : g_bad_width
         $error("irq_vec_ctl: VEC_W too narrow for the vector table");
      end
   endgenerate

   logic [IVC_PINS-1:0] pin_req;
   logic [IVC_PINS-1:0] pin_clr;
   logic [N-1:0]        pend;
   logic [N-1:0]        enable;
   logic [N-1:0]        allow;
   logic [N-1:0]        eligible;
   logic [N-1:0]        grant;
   logic [N-1:0]        act;
   logic [LW-1:0]       sel_idx;
   logic                take;

   assign take = ack & irq_out;

   // pin to level: pin 2 -> level 1, pin 1 -> level 4, pin 0 -> level 5
   assign pin_clr[2] = take & grant[LVL_PIN_HI];
   assign pin_clr[1] = take & grant[LVL_SHR_A] & shared_pin_sel[0];
   assign pin_clr[0] = take & grant[LVL_SHR_B] & shared_pin_sel[1];

   generate
      for (genvar j = 0; j < IVC_PINS; j++) begin : g_pin
         irq_pin_capture #(.SYNC_STAGES(PIN_SYNC_STAGES)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_req_n[j]),
            .edge_mode (ext_edge_mode[j]),
            .clr       (pin_clr[j]),
            .req       (pin_req[j])
         );
      end

      for (genvar l = 0; l < N; l++) begin : g_lvl
         if (l == LVL_SYSRST) begin : g_sysrst
            assign pend[l] = sys_rst_req;
         end else if (l == LVL_PIN_HI) begin : g_pin_hi
            assign pend[l] = pin_req[2];
         end else begin : g_evt
            logic ev;
            logic use_pin;
            logic pin_r;
            logic lat;
            assign ev = (l == LVL_P0_TX) ? sp0_tx_evt :
                        (l == LVL_P0_RX) ? sp0_rx_evt :
                        (l == LVL_SHR_A) ? sp1_tx_evt :
                        (l == LVL_SHR_B) ? sp1_rx_evt : tmr_evt;
            assign use_pin = (l == LVL_SHR_A) ? shared_pin_sel[0] :
                             (l == LVL_SHR_B) ? shared_pin_sel[1] : 1'b0;
            assign pin_r   = (l == LVL_SHR_A) ? pin_req[1] :
                             (l == LVL_SHR_B) ? pin_req[0] : 1'b0;
            irq_evt_latch u_lat (
               .clk    (clk),
               .rst_n  (rst_n),
               .evt    (ev),
               .accept (~use_pin),
               .clr    (take & grant[l]),
               .pend   (lat)
            );
            assign pend[l] = use_pin ? pin_r : lat;
         end
      end
   endgenerate

   assign enable   = {irq_mask, 1'b1};
   assign eligible = pend & enable & allow;

   irq_prio_pick #(.N(N), .IDX_W(LW)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (eligible),
      .grant (grant),
      .idx   (sel_idx),
      .any   (irq_out)
   );

   irq_nest_track #(.N(N)) u_nest (
      .clk     (clk),
      .rst_n   (rst_n),
      .nest_en (nest_en),
      .push    (take ? grant : '0),
      .pop     (rti),
      .act     (act),
      .allow   (allow)
   );

   assign vec_addr = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(sel_idx);

   // R1: the reset level wins whenever it is not already in service
   a_r1_sysrst_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rst_req && !act[LVL_SYSRST]) |-> (irq_out && vec_addr == VEC_W'(VEC_BASE)));
   // R3: a masked level never reaches the core
   a_r3_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && sel_idx != '0) |-> irq_mask[sel_idx - 1'b1]);
   // R10: without nesting only the reset level interrupts a routine
   a_r10_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
      (!nest_en && act != '0 && irq_out) |-> (vec_addr == VEC_W'(VEC_BASE)));
   // R11: a nested request outranks every in-service level
   a_r11_outranks: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && sel_idx != '0) |-> ((act & ((N'(1) << (sel_idx + 1'b1)) - N'(1))) == '0));
endmodule

// File: tb/tb_irq_vec_ctl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_rst_req = 1'b0;
   logic [2:0]  ext_req_n = 3'b111;
   logic [2:0]  ext_edge_mode = 3'b000;
   logic [1:0]  shared_pin_sel = 2'b11;
   logic        sp0_tx_evt = 1'b0, sp0_rx_evt = 1'b0;
   logic        sp1_tx_evt = 1'b0, sp1_rx_evt = 1'b0;
   logic        tmr_evt = 1'b0;
   logic [5:0]  irq_mask = 6'h3F;
   logic        nest_en = 1'b0;
   logic        ack = 1'b0;
   logic        rti = 1'b0;
   logic        irq_out;
   logic [15:0] vec_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_vec_ctl dut (
      .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req),
      .ext_req_n(ext_req_n), .ext_edge_mode(ext_edge_mode),
      .shared_pin_sel(shared_pin_sel),
      .sp0_tx_evt(sp0_tx_evt), .sp0_rx_evt(sp0_rx_evt),
      .sp1_tx_evt(sp1_tx_evt), .sp1_rx_evt(sp1_rx_evt),
      .tmr_evt(tmr_evt), .irq_mask(irq_mask), .nest_en(nest_en),
      .ack(ack), .rti(rti), .irq_out(irq_out), .vec_addr(vec_addr)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, bit exp_irq, int exp_vec);
      checks++;
      if (irq_out !== exp_irq || (exp_irq && vec_addr !== 16'(exp_vec))) begin
         failures++;
         $display("FAIL %s: irq=%0b vec=0x%0h expected irq=%0b vec=0x%0h",
                  req, irq_out, vec_addr, exp_irq, exp_vec);
      end
   endtask

   task automatic do_ack();
      ack = 1'b1; step(); ack = 1'b0;
   endtask

   task automatic do_rti();
      rti = 1'b1; step(); rti = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 12; k++) begin
         if (irq_out) do_ack();
         do_rti();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("reset state", 1'b0, 0);
      rst_n = 1'b1;
      step();
      chk("reset state after release", 1'b0, 0);

      // R3 R4 R2 R5 R7: every pending subset against every mask
      for (int p = 0; p < 64; p++) begin
         ext_req_n[2] = ~p[0];
         ext_req_n[1] = ~p[3];
         ext_req_n[0] = ~p[4];
         sp0_tx_evt = p[1]; sp0_rx_evt = p[2]; tmr_evt = p[5];
         step();
         sp0_tx_evt = 1'b0; sp0_rx_evt = 1'b0; tmr_evt = 1'b0;
         for (int m = 0; m < 64; m++) begin
            int hit;
            irq_mask = 6'(m);
            step();
            hit = 0;
            for (int k = 6; k >= 1; k--) if (p[k-1] && m[k-1]) hit = k;
            chk("R3/R4 sweep", hit != 0, hit * 4);
         end
         ext_req_n = 3'b111;
         irq_mask = 6'h3F;
         step();
         drain();
      end
      chk("R4 sweep cleanup", 1'b0, 0);

      // R1: reset level ignores the mask
      irq_mask = 6'h00;
      sys_rst_req = 1'b1; step();
      chk("R1 unmaskable", 1'b1, 0);
      do_ack(); sys_rst_req = 1'b0; do_rti();
      irq_mask = 6'h3F;
      // R1: reset level pre-empts with nesting off
      tmr_evt = 1'b1; step(); tmr_evt = 1'b0;
      chk("R7 timer latched", 1'b1, 'h18);
      do_ack();
      sys_rst_req = 1'b1; step();
      chk("R1 pre-empts without nesting", 1'b1, 0);
      do_ack(); sys_rst_req = 1'b0; do_rti(); do_rti();
      chk("R12 all retired", 1'b0, 0);

      // R6: edge mode latches and is cleared by ack
      ext_edge_mode = 3'b100;
      step();
      ext_req_n[2] = 1'b0; step();
      ext_req_n[2] = 1'b1; step();
      chk("R6 edge held after rise", 1'b1, 'h04);
      do_ack();
      do_rti();
      chk("R6 latch cleared by ack", 1'b0, 0);
      ext_edge_mode = 3'b000;

      // R5: level mode is not latched
      ext_req_n[2] = 1'b0; step();
      chk("R5 level low", 1'b1, 'h04);
      ext_req_n[2] = 1'b1; step();
      chk("R5 level released", 1'b0, 0);

      // R8: unselected source has no effect
      shared_pin_sel = 2'b11;
      sp1_tx_evt = 1'b1; sp1_rx_evt = 1'b1; step();
      sp1_tx_evt = 1'b0; sp1_rx_evt = 1'b0; step();
      chk("R8 port events ignored when pins own slots", 1'b0, 0);
      shared_pin_sel = 2'b00;
      ext_req_n[1:0] = 2'b00; step();
      chk("R8 pins ignored when ports own slots", 1'b0, 0);
      sp1_rx_evt = 1'b1; step(); sp1_rx_evt = 1'b0;
      chk("R8 port receive on shared B", 1'b1, 'h14);
      sp1_tx_evt = 1'b1; step(); sp1_tx_evt = 1'b0;
      chk("R8 port transmit on shared A", 1'b1, 'h10);
      ext_req_n = 3'b111;
      drain();
      shared_pin_sel = 2'b11;
      chk("R8 shared drained", 1'b0, 0);

      // R9: ack without request does nothing
      do_ack();
      tmr_evt = 1'b1; step(); tmr_evt = 1'b0;
      chk("R9 stray ack ignored", 1'b1, 'h18);

      // R10: nesting off blocks while in service
      do_ack();
      ext_req_n[2] = 1'b0; step();
      chk("R10 blocked while busy", 1'b0, 0);
      do_rti();
      chk("R10 released after rti", 1'b1, 'h04);
      do_ack(); ext_req_n[2] = 1'b1; do_rti();
      chk("R12 idle again", 1'b0, 0);

      // R11 R12: nested stack with a middle-priority request
      nest_en = 1'b1;
      tmr_evt = 1'b1; step(); tmr_evt = 1'b0;
      do_ack();
      ext_req_n[2] = 1'b0; step();
      chk("R11 higher pre-empts", 1'b1, 'h04);
      do_ack(); ext_req_n[2] = 1'b1;
      sp0_rx_evt = 1'b1; step(); sp0_rx_evt = 1'b0;
      chk("R11 lower than current held", 1'b0, 0);
      do_rti();
      chk("R12 return exposes middle level", 1'b1, 'h0C);
      do_ack();
      tmr_evt = 1'b1; step(); tmr_evt = 1'b0;
      chk("R11 timer below current held", 1'b0, 0);
      do_rti();
      chk("R11 equal level not re-issued", 1'b0, 0);
      do_rti();
      chk("R12 empty stack releases timer", 1'b1, 'h18);
      do_ack(); do_rti();
      chk("R12 final idle", 1'b0, 0);
      nest_en = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule